// File: doc/BRIEF.md
# Galois-form maximal-length pseudo-random sequence generator

This block produces a pseudo-random sequence of WIDTH-bit words from a shift register whose stages are separated, at selected positions, by two-input XOR gates. The bit leaving the top stage is fed back into the bottom stage and also into every stage boundary named by a nonzero coefficient of the `TAPS` parameter. One step is therefore a multiplication by x modulo a primitive polynomial. With a primitive polynomial, the register runs through every nonzero WIDTH-bit value once before it comes back to its start value.

`TAPS` holds the polynomial's coefficients below the leading term: bit i is the coefficient of x^i. Bit 0 (the constant term) is always taken as present. For example, x^4+x+1 gives `4'h3`, x^8+x^4+x^3+x^2+1 gives `8'h1D`, and x^16+x^12+x^3+x+1 gives `16'h100B`.

Each clock, a priority decode chooses one of four operations:
- **INIT** when `rst` is high.
- **SEED** when `load` is high.
- **ADVANCE** when `step_en` is high.
- **HOLD** otherwise.

The operation is chosen afresh on every clock, so any operation can follow any other. The named transitions are:
- INIT→ADVANCE: the run starts from value 1.
- SEED→ADVANCE: the run starts from a loaded value.
- ADVANCE→HOLD: the run pauses.
- HOLD→ADVANCE: the run resumes.
- Any operation→INIT or SEED: the run restarts.

Top module: `galois_prng`

## Requirements
- R1: One clock edge with `rst` high makes `state_q` equal to 1 (only bit 0 set).
- R2: With `rst` low and `load` high, a nonzero `seed` appears on `state_q` after the edge. `load` wins over `step_en`.
- R3: A load of an all-zero `seed` gives `state_q` equal to 1 instead of zero.
- R4: With `rst`, `load` and `step_en` all low, `state_q` keeps its value across the edge.
- R5: With `step_en` high and `rst` and `load` low, each edge shifts `state_q` left by one place, with a 0 entering bit 0. If the bit shifted out of the top was 1, the shifted word is then XORed with `TAPS` with bit 0 forced to 1.
- R6: With WIDTH=4 and TAPS=4'h3, stepping from 1 gives 2, 4, 8, 3, 6, 12, 11, 5, 10, 7, 14, 15, 13, 9 and then 1 again.
- R7: With a primitive polynomial, stepping from 1 first returns to 1 after exactly 2^WIDTH−1 steps, and `state_q` is never zero. This holds for widths 4, 8 and 16.
- R8: `rst` wins over `load`: with both high, `state_q` becomes 1 whatever `seed` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high; sets the state to 1 |
| load | input | 1 | Load `seed` into the state (all-zero is replaced by 1) |
| seed | input | WIDTH | Value to load |
| step_en | input | 1 | Advance the sequence by one step |
| state_q | output | WIDTH | Current register state |

## Verification
The hardest case to reach from the ports is the long-range property: a return to the start value after exactly 2^WIDTH−1 steps, with zero never visited. The 16-bit instance needs 65535 consecutive steps to show it. The bench runs instances of width 4, 8 and 16 side by side from a loaded value of 1, and records the step on which each one first shows 1 again. A behavioural model based on polynomial arithmetic is compared against every instance on every clock. Directed cycles cover the zero-seed substitution and the reset-over-load and load-over-step priorities.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_ADVANCE = 2'd1,
        OP_SEED    = 2'd2,
        OP_INIT    = 2'd3
    } lfsr_op_e;

endpackage

// File: rtl/lfsr_op_decode.sv
module lfsr_op_decode
    import lfsr_pkg::*;
(
    input  logic     rst,
    input  logic     load,
    input  logic     step_en,
    output lfsr_op_e op
);

    always_comb begin
        if (rst)
            op = OP_INIT;
        else if (load)
            op = OP_SEED;
        else if (step_en)
            op = OP_ADVANCE;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] seed_safe
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    always_comb begin
        seed_safe = (seed == '0) ? ONE : seed;
    end

endmodule

// File: rtl/lfsr_feedback_net.sv
module lfsr_feedback_net #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'h1D
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    logic fb;
    assign fb     = cur[TOP];
    assign nxt[0] = fb;

    for (genvar i = 1; i < WIDTH; i++) begin : g_stage
        if (TAPS[i]) begin : g_xor
            assign nxt[i] = cur[i-1] ^ fb;
        end else begin : g_wire
            assign nxt[i] = cur[i-1];
        end
    end

endmodule

// File: rtl/galois_prng.sv
module galois_prng
    import lfsr_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'h1D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] seed,
    input  logic             step_en,
    output logic [WIDTH-1:0] state_q
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    lfsr_op_e         op;
    logic [WIDTH-1:0] state_r;
    logic [WIDTH-1:0] stepped;
    logic [WIDTH-1:0] seed_safe;

    lfsr_op_decode u_dec (
        .rst     (rst),
        .load    (load),
        .step_en (step_en),
        .op      (op)
    );

    lfsr_seed_guard #(.WIDTH(WIDTH)) u_guard (
        .seed      (seed),
        .seed_safe (seed_safe)
    );

    lfsr_feedback_net #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
        .cur (state_r),
        .nxt (stepped)
    );

    // State register: one operation per clock
    always_ff @(posedge clk) begin
        unique case (op)
            OP_INIT:    state_r <= ONE;
            OP_SEED:    state_r <= seed_safe;
            OP_ADVANCE: state_r <= stepped;
            OP_HOLD:    state_r <= state_r;
        endcase
    end

    // Output process
    always_comb begin
        state_q = state_r;
    end

endmodule

// File: rtl/galois_prng_chk.sv
module galois_prng_chk #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'h1D
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic [WIDTH-1:0] seed,
    input logic             step_en,
    input logic [WIDTH-1:0] state_q
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    logic prev_rst_q = 1'b0;

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
        if (prev_rst_q) begin
            a_r1_reset_one: assert (state_q == ONE)
                else $error("R1 state not one after reset");
        end
    end

    a_r2_load_seed: assert property (@(posedge clk) disable iff (rst)
        (load && seed != '0) |=> state_q == $past(seed));

    a_r3_zero_seed: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> state_q == ONE);

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !step_en) |=> $stable(state_q));

    a_r5_step: assert property (@(posedge clk) disable iff (rst)
        (!load && step_en) |=>
            state_q == ({$past(state_q[WIDTH-2:0]), 1'b0} ^
                        ($past(state_q[WIDTH-1]) ? (TAPS | ONE) : '0)));

    a_r7_never_zero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

bind galois_prng galois_prng_chk #(.WIDTH(WIDTH), .TAPS(TAPS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .seed    (seed),
    .step_en (step_en),
    .state_q (state_q)
);

// File: tb/sim_galois_prng.sv
`timescale 1ns/1ps
module sim_galois_prng;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic        step_en = 1'b0;
    logic [15:0] seed = 16'h0;
    logic [3:0]  q4;
    logic [7:0]  q8;
    logic [15:0] q16;

    int errors = 0;
    int checks = 0;
    bit armed = 1'b0;
    bit done = 1'b0;
    int m4, m8, m16;

    always #2 clk = ~clk;

    galois_prng #(.WIDTH(4), .TAPS(4'h3)) u0 (
        .clk(clk), .rst(rst), .load(load), .seed(seed[3:0]),
        .step_en(step_en), .state_q(q4));
    galois_prng #(.WIDTH(8), .TAPS(8'h1D)) u1 (
        .clk(clk), .rst(rst), .load(load), .seed(seed[7:0]),
        .step_en(step_en), .state_q(q8));
    galois_prng #(.WIDTH(16), .TAPS(16'h100B)) u2 (
        .clk(clk), .rst(rst), .load(load), .seed(seed),
        .step_en(step_en), .state_q(q16));

    // Polynomial model: multiply by x, reduce by the full polynomial
    function automatic int mul_x(int v, int w, int poly);
        int t;
        t = v << 1;
        if (((t >> w) & 1) == 1) t = t ^ poly;
        return t;
    endfunction

    function automatic int seeded(int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m4 <= 1; m8 <= 1; m16 <= 1; armed <= 1'b1;
        end else if (load) begin
            m4  <= seeded(int'(seed[3:0]));
            m8  <= seeded(int'(seed[7:0]));
            m16 <= seeded(int'(seed));
        end else if (step_en) begin
            m4  <= mul_x(m4, 4, 'h13);
            m8  <= mul_x(m8, 8, 'h11D);
            m16 <= mul_x(m16, 16, 'h1100B);
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R5: cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (armed && !done) begin
            check("R5 w4",  int'(q4),  m4);
            check("R5 w8",  int'(q8),  m8);
            check("R5 w16", int'(q16), m16);
        end
    end

    initial begin
        int tbl [15] = '{1, 2, 4, 8, 3, 6, 12, 11, 5, 10, 7, 14, 15, 13, 9};
        int h4, h8, h16;
        int f4, f8, f16;
        int zero_hit;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        check("R1 w4", int'(q4), 1);
        check("R1 w8", int'(q8), 1);
        check("R1 w16", int'(q16), 1);

        step_en = 1'b1;
        for (int i = 1; i <= 15; i++) begin
            tick();
            check("R6 sequence", int'(q4), tbl[i % 15]);
        end

        step_en = 1'b0;
        h4 = int'(q4); h8 = int'(q8); h16 = int'(q16);
        repeat (4) tick();
        check("R4 hold w4", int'(q4), h4);
        check("R4 hold w8", int'(q8), h8);
        check("R4 hold w16", int'(q16), h16);

        seed = 16'hA5C3; load = 1'b1; step_en = 1'b1;
        tick();
        load = 1'b0; step_en = 1'b0;
        check("R2 load w16", int'(q16), 'hA5C3);
        check("R2 load w8", int'(q8), 'hC3);
        check("R2 load w4", int'(q4), 'h3);

        seed = 16'h0; load = 1'b1;
        tick();
        load = 1'b0;
        check("R3 zero seed w4", int'(q4), 1);
        check("R3 zero seed w8", int'(q8), 1);
        check("R3 zero seed w16", int'(q16), 1);

        step_en = 1'b1;
        tick(); tick();
        step_en = 1'b0;
        rst = 1'b1; load = 1'b1; seed = 16'hBEEF;
        tick();
        rst = 1'b0; load = 1'b0;
        check("R8 reset over load w4", int'(q4), 1);
        check("R8 reset over load w8", int'(q8), 1);
        check("R8 reset over load w16", int'(q16), 1);

        seed = 16'h0001; load = 1'b1;
        tick();
        load = 1'b0; step_en = 1'b1;
        f4 = 0; f8 = 0; f16 = 0; zero_hit = 0;
        for (int s = 1; s <= 65535; s++) begin
            tick();
            if (q4 == 0 || q8 == 0 || q16 == 0) zero_hit = 1;
            if (f4 == 0 && q4 == 4'd1) f4 = s;
            if (f8 == 0 && q8 == 8'd1) f8 = s;
            if (f16 == 0 && q16 == 16'd1) f16 = s;
        end
        step_en = 1'b0;
        check("R7 period w4", f4, 15);
        check("R7 period w8", f8, 255);
        check("R7 period w16", f16, 65535);
        check("R7 zero never seen", zero_hit, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule